// File: doc/BRIEF.md
# Multi-core interrupt distributor

This block gathers interrupt requests from peripherals and from software and passes each one on to a small set of processor cores. The default build serves two cores and 64 interrupt IDs. Each core receives its own vector of forwarded interrupts, along with the best candidate in that vector by priority. Each core acknowledges an interrupt and later signals its completion through its own pins.

IDs 0 to 31 exist once per core. IDs 0 to 15 are raised by software, and IDs 16 to 31 come from private per-core peripheral lines. IDs 32 and up come from shared peripheral lines. A per-ID target mask sends each shared interrupt to any set of cores. A software interrupt is raised by one register write and stays pending until it is acknowledged. It also remembers which bus master raised it.

The register port is a single-cycle write port with a combinational read. Its map is:

| Offset | Contents |
|---|---|
| 0x000 | Control |
| 0x004 | Software-interrupt trigger |
| 0x100 + 4·w | Enable word w |
| 0x400 + 4·id | Priority of an ID |
| 0x800 + 4·id | Target mask of an ID |

Top module: `irq_distributor`

## Requirements
- R1: After reset, all of the following are zero: the control bit, every enable bit, every priority and every target mask. `fwd_o` and `best_vld_o` are also zero, and a read of any register returns 0.
- R2: Nothing is forwarded to any core while bit 0 of the control register (offset 0x000) is clear. A software interrupt that is pending reappears when that bit is set again.
- R3: An interrupt is forwarded only if its enable bit is set. The enable bit for ID `32w+j` is bit j of the enable word at 0x100+4·w.
- R4: Enable word 0, which covers IDs 0 to 31, is banked by core. A write to it changes only the copy of the core whose number is on `reg_master`. The private line for core c and ID 16+i is `ppi_in[16c+i]`.
- R5: Shared ID k is routed to core c only when bit c of its target word (0x800+4·k) is set. A write to the target word of an ID below 32 is ignored, and that word reads 0.
- R6: A write to 0x004 makes one software interrupt pending on each core whose bit is set in bits [16+c]. The SGI number is taken from bits [3:0].
  - The interrupt stays pending after the write, until that core acknowledges it.
  - The writer's `reg_master` is recorded for that core and SGI, at bits `(16c+i)·CORE_W` of `sgi_src_o`.
- R7: Peripheral inputs are level-sensitive. A private or shared interrupt is forwarded only while its input is high and the interrupt is not active.
- R8: Acknowledging an ID that is forwarded to the acknowledging core has these effects:
  - For a software interrupt, it clears that core's pending copy.
  - For a private interrupt, it marks that core's copy active until the same core signals end of interrupt for it.
  - An acknowledge of an ID that is not forwarded to that core has no effect.
- R9: Acknowledging a shared ID makes it active for all cores. It is not forwarded to any core until some core signals end of interrupt for that ID.
- R10: `best_id_o` of a core is the forwarded ID with the numerically lowest priority, where a lower value means a higher priority. If two IDs have the same priority, the lower ID wins. `best_vld_o` is 0 when nothing is forwarded to that core.
- R11: Reads return the stored values, as follows:
  - Control bit 0.
  - The enable words; word 0 comes from the copy of the core on `reg_master`.
  - The priority in bits [7:0].
  - The target mask in bits [NUM_CORES-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_master | input | CORE_W | Number of the requesting core, used for banking and as the SGI source |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| ppi_in | input | NUM_CORES*16 | Private peripheral lines, 16 per core |
| spi_in | input | NUM_IDS-32 | Shared peripheral lines, one per ID from 32 up |
| ack_vld | input | NUM_CORES | Acknowledge strobe, one per core |
| ack_id | input | NUM_CORES*ID_W | ID being acknowledged, per core |
| eoi_vld | input | NUM_CORES | End-of-interrupt strobe, one per core |
| eoi_id | input | NUM_CORES*ID_W | ID being completed, per core |
| fwd_o | output | NUM_CORES*NUM_IDS | Forwarded interrupts per core, with core c at bits [c*NUM_IDS +: NUM_IDS] |
| best_vld_o | output | NUM_CORES | High when a core has at least one forwarded interrupt |
| best_id_o | output | NUM_CORES*ID_W | Highest-priority forwarded ID per core |
| sgi_src_o | output | NUM_CORES*16*CORE_W | Recorded requester of each SGI, per core |

## Verification
The interrupt state is held in a few registers. Any error in that state shows up in `fwd_o` one cycle after the write, acknowledge or end of interrupt that caused it, because the forwarded vector is built combinationally from that state.

Some errors show only on a core other than the one that acted. A lost active bit lets an acknowledged line reappear on the next cycle. A shared active bit kept per core would leave the interrupt visible on the other core. A software interrupt cleared by its write strobe would vanish on the first idle cycle.

The priority picker depends only on the current vector, so a wrong choice or a wrong tie-break appears in `best_id_o` in the same cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   localparam int ADDR_W   = 12;
   localparam int DATA_W   = 32;
   localparam int PRIV_IDS = 32;
   localparam int SGI_IDS  = 16;
   localparam int PPI_IDS  = PRIV_IDS - SGI_IDS;

   localparam logic [ADDR_W-1:0] A_CTRL = 12'h000;
   localparam logic [ADDR_W-1:0] A_SGI  = 12'h004;

   function automatic logic [ADDR_W-1:0] en_addr(input int w);
      return ADDR_W'(32'h100 + 4 * w);
   endfunction

   function automatic logic [ADDR_W-1:0] prio_addr(input int id);
      return ADDR_W'(32'h400 + 4 * id);
   endfunction

   function automatic logic [ADDR_W-1:0] tgt_addr(input int id);
      return ADDR_W'(32'h800 + 4 * id);
   endfunction

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
   import irqd_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int NUM_IDS   = 64,
   parameter int PRIO_W    = 8,
   parameter int CORE_W    = 1,
   localparam int NUM_SHR  = NUM_IDS - PRIV_IDS
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  we,
   input  logic [ADDR_W-1:0]                     addr,
   input  logic [DATA_W-1:0]                     wdata,
   input  logic [CORE_W-1:0]                     master,
   output logic                                  glob_en,
   output logic [NUM_CORES-1:0][PRIV_IDS-1:0]    en_priv,
   output logic [NUM_SHR-1:0]                    en_shr,
   output logic [NUM_IDS-1:0][PRIO_W-1:0]        prio,
   output logic [NUM_SHR-1:0][NUM_CORES-1:0]     tgt,
   output logic [DATA_W-1:0]                     rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en <= 1'b0;
         en_priv <= '0;
         en_shr  <= '0;
         prio    <= '0;
         tgt     <= '0;
      end else if (we) begin
         if (addr == A_CTRL) begin
            glob_en <= wdata[0];
         end
         for (int c = 0; c < NUM_CORES; c++) begin
            if (addr == en_addr(0) && int'(master) == c) begin
               en_priv[c] <= wdata;
            end
         end
         for (int s = 0; s < NUM_SHR; s++) begin
            if (addr == en_addr(1 + s / 32)) begin
               en_shr[s] <= wdata[s % 32];
            end
         end
         for (int i = 0; i < NUM_IDS; i++) begin
            if (addr == prio_addr(i)) begin
               prio[i] <= wdata[PRIO_W-1:0];
            end
         end
         for (int s = 0; s < NUM_SHR; s++) begin
            if (addr == tgt_addr(PRIV_IDS + s)) begin
               tgt[s] <= wdata[NUM_CORES-1:0];
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CTRL) begin
         rdata[0] = glob_en;
      end
      for (int c = 0; c < NUM_CORES; c++) begin
         if (addr == en_addr(0) && int'(master) == c) begin
            rdata = en_priv[c];
         end
      end
      for (int s = 0; s < NUM_SHR; s++) begin
         if (addr == en_addr(1 + s / 32)) begin
            rdata[s % 32] = en_shr[s];
         end
      end
      for (int i = 0; i < NUM_IDS; i++) begin
         if (addr == prio_addr(i)) begin
            rdata[PRIO_W-1:0] = prio[i];
         end
      end
      for (int s = 0; s < NUM_SHR; s++) begin
         if (addr == tgt_addr(PRIV_IDS + s)) begin
            rdata[NUM_CORES-1:0] = tgt[s];
         end
      end
   end

endmodule

// File: rtl/irqd_core.sv
module irqd_core
   import irqd_pkg::*;
#(
   parameter int NUM_IDS  = 64,
   parameter int CORE_W   = 1,
   parameter int ID_W     = 6,
   localparam int NUM_SHR = NUM_IDS - PRIV_IDS
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             glob_en,
   input  logic [PRIV_IDS-1:0]              en_priv,
   input  logic [NUM_SHR-1:0]               en_shr,
   input  logic [NUM_SHR-1:0]               tgt_me,
   input  logic [PPI_IDS-1:0]               ppi,
   input  logic [NUM_SHR-1:0]               spi,
   input  logic [NUM_SHR-1:0]               shr_active,
   input  logic                             sgi_set,
   input  logic [3:0]                       sgi_id,
   input  logic [CORE_W-1:0]                sgi_master,
   input  logic                             ack_vld,
   input  logic [ID_W-1:0]                  ack_id,
   input  logic                             eoi_vld,
   input  logic [ID_W-1:0]                  eoi_id,
   output logic [NUM_IDS-1:0]               fwd,
   output logic [NUM_SHR-1:0]               shr_ack,
   output logic [NUM_SHR-1:0]               shr_eoi,
   output logic [SGI_IDS-1:0][CORE_W-1:0]   sgi_src
);

   logic [SGI_IDS-1:0]     sgi_pend;
   logic [PPI_IDS-1:0]     ppi_act;
   logic [NUM_IDS-1:0]     pend;
   logic [NUM_IDS-1:0]     gate;
   logic                   ack_in;
   logic [NUM_IDS-1:0]     ack_hit;
   logic [NUM_IDS-1:SGI_IDS] eoi_hit;

   always_comb begin
      for (int i = 0; i < SGI_IDS; i++) begin
         pend[i] = sgi_pend[i];
         gate[i] = en_priv[i];
      end
      for (int i = 0; i < PPI_IDS; i++) begin
         pend[SGI_IDS+i] = ppi[i] & ~ppi_act[i];
         gate[SGI_IDS+i] = en_priv[SGI_IDS+i];
      end
      for (int s = 0; s < NUM_SHR; s++) begin
         pend[PRIV_IDS+s] = spi[s] & ~shr_active[s];
         gate[PRIV_IDS+s] = en_shr[s] & tgt_me[s];
      end
   end

   assign fwd    = glob_en ? (pend & gate) : '0;
   assign ack_in = ack_vld && (int'(ack_id) < NUM_IDS) && fwd[ack_id];

   always_comb begin
      for (int i = 0; i < NUM_IDS; i++) begin
         ack_hit[i] = ack_in && (ack_id == ID_W'(i));
      end
      for (int i = SGI_IDS; i < NUM_IDS; i++) begin
         eoi_hit[i] = eoi_vld && (eoi_id == ID_W'(i));
      end
      for (int s = 0; s < NUM_SHR; s++) begin
         shr_ack[s] = ack_hit[PRIV_IDS+s];
         shr_eoi[s] = eoi_hit[PRIV_IDS+s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sgi_pend <= '0;
         sgi_src  <= '0;
         ppi_act  <= '0;
      end else begin
         for (int i = 0; i < SGI_IDS; i++) begin
            if (ack_hit[i]) begin
               sgi_pend[i] <= 1'b0;
            end
            if (sgi_set && sgi_id == 4'(i)) begin
               sgi_pend[i] <= 1'b1;
               sgi_src[i]  <= sgi_master;
            end
         end
         for (int i = 0; i < PPI_IDS; i++) begin
            if (eoi_hit[SGI_IDS+i]) begin
               ppi_act[i] <= 1'b0;
            end
            if (ack_hit[SGI_IDS+i]) begin
               ppi_act[i] <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
   parameter int NUM_IDS = 64,
   parameter int PRIO_W  = 8,
   parameter int ID_W    = 6
) (
   input  logic [NUM_IDS-1:0]              req,
   input  logic [NUM_IDS-1:0][PRIO_W-1:0]  prio,
   output logic                            vld,
   output logic [ID_W-1:0]                 id
);

   logic [PRIO_W-1:0] best;

   always_comb begin
      vld  = 1'b0;
      id   = '0;
      best = '1;
      for (int i = 0; i < NUM_IDS; i++) begin
         if (req[i] && (!vld || prio[i] < best)) begin
            vld  = 1'b1;
            id   = ID_W'(i);
            best = prio[i];
         end
      end
   end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import irqd_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int NUM_IDS   = 64,
   parameter int PRIO_W    = 8,
   localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int ID_W     = $clog2(NUM_IDS),
   localparam int NUM_SHR  = NUM_IDS - PRIV_IDS
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [ADDR_W-1:0]                 reg_addr,
   input  logic [DATA_W-1:0]                 reg_wdata,
   input  logic [CORE_W-1:0]                 reg_master,
   output logic [DATA_W-1:0]                 reg_rdata,
   input  logic [NUM_CORES*PPI_IDS-1:0]      ppi_in,
   input  logic [NUM_SHR-1:0]                spi_in,
   input  logic [NUM_CORES-1:0]              ack_vld,
   input  logic [NUM_CORES*ID_W-1:0]         ack_id,
   input  logic [NUM_CORES-1:0]              eoi_vld,
   input  logic [NUM_CORES*ID_W-1:0]         eoi_id,
   output logic [NUM_CORES*NUM_IDS-1:0]      fwd_o,
   output logic [NUM_CORES-1:0]              best_vld_o,
   output logic [NUM_CORES*ID_W-1:0]         best_id_o,
   output logic [NUM_CORES*SGI_IDS*CORE_W-1:0] sgi_src_o
);

   if (NUM_CORES < 1 || NUM_CORES > 8) begin : g_bad_cores
      $error("irq_distributor: NUM_CORES must be 1..8");
   end
   if (NUM_IDS <= PRIV_IDS || NUM_IDS > 256) begin : g_bad_ids
      $error("irq_distributor: NUM_IDS must be 33..256");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("irq_distributor: PRIO_W must be 1..8");
   end

   logic                                    glob_en;
   logic [NUM_CORES-1:0][PRIV_IDS-1:0]      en_priv;
   logic [NUM_SHR-1:0]                      en_shr;
   logic [NUM_IDS-1:0][PRIO_W-1:0]          prio;
   logic [NUM_SHR-1:0][NUM_CORES-1:0]       tgt;
   logic [NUM_CORES-1:0][NUM_SHR-1:0]       tgt_col;
   logic [NUM_CORES-1:0][NUM_SHR-1:0]       shr_ack;
   logic [NUM_CORES-1:0][NUM_SHR-1:0]       shr_eoi;
   logic [NUM_SHR-1:0]                      shr_ack_any;
   logic [NUM_SHR-1:0]                      shr_eoi_any;
   logic [NUM_SHR-1:0]                      shr_active;
   logic                                    sgi_wr;

   assign sgi_wr = reg_we && (reg_addr == A_SGI);

   irqd_regs #(
      .NUM_CORES (NUM_CORES),
      .NUM_IDS   (NUM_IDS),
      .PRIO_W    (PRIO_W),
      .CORE_W    (CORE_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .master  (reg_master),
      .glob_en (glob_en),
      .en_priv (en_priv),
      .en_shr  (en_shr),
      .prio    (prio),
      .tgt     (tgt),
      .rdata   (reg_rdata)
   );

   always_comb begin
      for (int c = 0; c < NUM_CORES; c++) begin
         for (int s = 0; s < NUM_SHR; s++) begin
            tgt_col[c][s] = tgt[s][c];
         end
      end
      for (int s = 0; s < NUM_SHR; s++) begin
         shr_ack_any[s] = 1'b0;
         shr_eoi_any[s] = 1'b0;
         for (int c = 0; c < NUM_CORES; c++) begin
            shr_ack_any[s] = shr_ack_any[s] | shr_ack[c][s];
            shr_eoi_any[s] = shr_eoi_any[s] | shr_eoi[c][s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shr_active <= '0;
      end else begin
         for (int s = 0; s < NUM_SHR; s++) begin
            if (shr_eoi_any[s]) begin
               shr_active[s] <= 1'b0;
            end
            if (shr_ack_any[s]) begin
               shr_active[s] <= 1'b1;
            end
         end
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [SGI_IDS-1:0][CORE_W-1:0] src_c;

      irqd_core #(
         .NUM_IDS (NUM_IDS),
         .CORE_W  (CORE_W),
         .ID_W    (ID_W)
      ) u_core (
         .clk        (clk),
         .rst_n      (rst_n),
         .glob_en    (glob_en),
         .en_priv    (en_priv[c]),
         .en_shr     (en_shr),
         .tgt_me     (tgt_col[c]),
         .ppi        (ppi_in[c*PPI_IDS +: PPI_IDS]),
         .spi        (spi_in),
         .shr_active (shr_active),
         .sgi_set    (sgi_wr && reg_wdata[16+c]),
         .sgi_id     (reg_wdata[3:0]),
         .sgi_master (reg_master),
         .ack_vld    (ack_vld[c]),
         .ack_id     (ack_id[c*ID_W +: ID_W]),
         .eoi_vld    (eoi_vld[c]),
         .eoi_id     (eoi_id[c*ID_W +: ID_W]),
         .fwd        (fwd_o[c*NUM_IDS +: NUM_IDS]),
         .shr_ack    (shr_ack[c]),
         .shr_eoi    (shr_eoi[c]),
         .sgi_src    (src_c)
      );

      assign sgi_src_o[c*SGI_IDS*CORE_W +: SGI_IDS*CORE_W] = src_c;

      irqd_pick #(
         .NUM_IDS (NUM_IDS),
         .PRIO_W  (PRIO_W),
         .ID_W    (ID_W)
      ) u_pick (
         .req  (fwd_o[c*NUM_IDS +: NUM_IDS]),
         .prio (prio),
         .vld  (best_vld_o[c]),
         .id   (best_id_o[c*ID_W +: ID_W])
      );
   end

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
   parameter int NUM_CORES = 2,
   parameter int NUM_IDS   = 64,
   localparam int ID_W     = $clog2(NUM_IDS)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          reg_we,
   input logic [11:0]                   reg_addr,
   input logic                          ctrl_d,
   input logic [NUM_CORES*NUM_IDS-1:0]  fwd_o,
   input logic [NUM_CORES-1:0]          best_vld_o,
   input logic [NUM_CORES*ID_W-1:0]     best_id_o,
   input logic [NUM_CORES-1:0]          ack_vld,
   input logic [NUM_CORES*ID_W-1:0]     ack_id
);

   logic sh_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_en <= 1'b0;
      end else if (reg_we && reg_addr == 12'h000) begin
         sh_en <= ctrl_d;
      end
   end

   function automatic logic any_core(input logic [NUM_CORES*NUM_IDS-1:0] v,
                                     input logic [ID_W-1:0] id);
      logic r;
      r = 1'b0;
      for (int k = 0; k < NUM_CORES; k++) begin
         r = r | v[k*NUM_IDS + int'(id)];
      end
      return r;
   endfunction

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
      logic [NUM_IDS-1:0] f;
      logic [ID_W-1:0]    aid;
      logic [ID_W-1:0]    bid;
      assign f   = fwd_o[c*NUM_IDS +: NUM_IDS];
      assign aid = ack_id[c*ID_W +: ID_W];
      assign bid = best_id_o[c*ID_W +: ID_W];

      a_r2_gate_off : assert property (@(posedge clk) disable iff (!rst_n)
         !sh_en |-> (f == '0));

      a_r10_vld_match : assert property (@(posedge clk) disable iff (!rst_n)
         best_vld_o[c] == (|f));

      a_r10_best_pending : assert property (@(posedge clk) disable iff (!rst_n)
         best_vld_o[c] |-> f[bid]);

      a_r8_ack_private : assert property (@(posedge clk) disable iff (!rst_n)
         (ack_vld[c] && aid >= 16 && aid < 32 && f[aid]) |=> !f[$past(aid)]);

      a_r9_ack_shared : assert property (@(posedge clk) disable iff (!rst_n)
         (ack_vld[c] && aid >= 32 && int'(aid) < NUM_IDS && f[aid])
            |=> !any_core(fwd_o, $past(aid)));
   end

endmodule

bind irq_distributor irqd_checker #(
   .NUM_CORES (NUM_CORES),
   .NUM_IDS   (NUM_IDS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .ctrl_d     (reg_wdata[0]),
   .fwd_o      (fwd_o),
   .best_vld_o (best_vld_o),
   .best_id_o  (best_id_o),
   .ack_vld    (ack_vld),
   .ack_id     (ack_id)
);

// File: tb/irq_distributor_test.sv
module irq_distributor_test;

   localparam int NC = 2;
   localparam int N  = 64;
   localparam int IW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_master = 1'b0;
   logic [31:0]   reg_rdata;
   logic [NC*16-1:0] ppi_in = '0;
   logic [N-33:0] spi_in = '0;
   logic [NC-1:0] ack_vld = '0;
   logic [NC*IW-1:0] ack_id = '0;
   logic [NC-1:0] eoi_vld = '0;
   logic [NC*IW-1:0] eoi_id = '0;
   logic [NC*N-1:0] fwd_o;
   logic [NC-1:0] best_vld_o;
   logic [NC*IW-1:0] best_id_o;
   logic [NC*16-1:0] sgi_src_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0]  mprio [N];
   logic [1:0]  mtgt  [N];
   logic [31:0] men_shr;
   logic        gen;

   always #4 clk = ~clk;

   irq_distributor uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_master(reg_master), .reg_rdata(reg_rdata),
      .ppi_in(ppi_in), .spi_in(spi_in), .ack_vld(ack_vld), .ack_id(ack_id),
      .eoi_vld(eoi_vld), .eoi_id(eoi_id), .fwd_o(fwd_o),
      .best_vld_o(best_vld_o), .best_id_o(best_id_o), .sgi_src_o(sgi_src_o)
   );

   task automatic chk(input logic ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] fw(input int c);
      return fwd_o[c*N +: N];
   endfunction

   function automatic logic [63:0] exp_shr(input int c, input logic [31:0] spi);
      logic [63:0] v;
      v = '0;
      for (int s = 0; s < 32; s++) begin
         v[32+s] = gen & spi[s] & men_shr[s] & mtgt[32+s][c];
      end
      return v;
   endfunction

   function automatic logic [6:0] exp_best(input logic [63:0] v);
      logic       f;
      logic [5:0] id;
      logic [7:0] b;
      f = 1'b0; id = '0; b = 8'hff;
      for (int i = 0; i < N; i++) begin
         if (v[i] && (!f || mprio[i] < b)) begin
            f = 1'b1; id = 6'(i); b = mprio[i];
         end
      end
      return {f, id};
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic m);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_master = m;
      @(negedge clk);
      reg_we = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [11:0] a, input logic m, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_master = m;
      #1;
      d = reg_rdata;
   endtask

   task automatic ack(input int c, input int id);
      @(negedge clk);
      ack_vld[c] = 1'b1; ack_id[c*IW +: IW] = 6'(id);
      @(negedge clk);
      ack_vld = '0;
      #1;
   endtask

   task automatic eoi(input int c, input int id);
      @(negedge clk);
      eoi_vld[c] = 1'b1; eoi_id[c*IW +: IW] = 6'(id);
      @(negedge clk);
      eoi_vld = '0;
      #1;
   endtask

   task automatic chk_shared(input string tag);
      for (int c = 0; c < NC; c++) begin
         logic [63:0] e;
         logic [6:0]  b;
         e = exp_shr(c, spi_in);
         b = exp_best(e);
         chk(fw(c) == e, tag, fw(c), e);
         chk(best_vld_o[c] == b[6] && (!b[6] || best_id_o[c*IW +: IW] == b[5:0]),
             "R10 best pick", 64'({best_vld_o[c], best_id_o[c*IW +: IW]}), 64'(b));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] lf;
      gen = 1'b0;
      men_shr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1 reset state
      chk(fwd_o == '0, "R1 fwd after reset", 64'(fwd_o), 0);
      chk(best_vld_o == '0, "R1 best_vld after reset", 64'(best_vld_o), 0);
      rd(12'h000, 1'b0, d); chk(d == 0, "R1 ctrl reset", 64'(d), 0);
      rd(12'h4A0, 1'b0, d); chk(d == 0, "R1 prio reset", 64'(d), 0);
      rd(12'h884, 1'b0, d); chk(d == 0, "R1 target reset", 64'(d), 0);

      for (int i = 0; i < N; i++) begin
         mprio[i] = 8'((i * 53 + 7) % 256);
         mtgt[i]  = (i >= 32) ? 2'(i % 4) : 2'b00;
         wr(12'(12'h400 + 4 * i), 32'(mprio[i]), 1'b0);
         if (i >= 32) wr(12'(12'h800 + 4 * i), 32'(mtgt[i]), 1'b0);
      end
      men_shr = 32'hffff_ffff;
      wr(12'h104, men_shr, 1'b0);

      // R2 global enable off
      @(negedge clk); spi_in = '1; #1;
      chk(fwd_o == '0, "R2 disabled blocks all", 64'(fwd_o), 0);
      wr(12'h000, 32'h1, 1'b0);
      gen = 1'b1;

      // R5 routing sweep, one shared line at a time
      for (int s = 0; s < 32; s++) begin
         @(negedge clk); spi_in = 32'(1) << s; #1;
         chk_shared("R5 routing one-hot");
      end

      // R7/R10 mixed patterns
      lf = 32'hACE1_1234;
      for (int k = 0; k < 24; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         @(negedge clk); spi_in = lf; #1;
         chk_shared("R7 level pattern");
      end

      // R3 enable gating
      men_shr = ~((32'(1) << 3) | (32'(1) << 20));
      wr(12'h104, men_shr, 1'b0);
      @(negedge clk); spi_in = '1; #1;
      chk_shared("R3 enable gating");
      chk(fw(0)[35] == 1'b0 && fw(1)[35] == 1'b0, "R3 id35 disabled",
          64'({fw(0)[35], fw(1)[35]}), 0);
      men_shr = 32'hffff_ffff;
      wr(12'h104, men_shr, 1'b0);

      // R10 tie on equal priority
      mprio[33] = 8'd5; mprio[37] = 8'd5;
      wr(12'h484, 32'd5, 1'b0);
      wr(12'h494, 32'd5, 1'b0);
      @(negedge clk); spi_in = (32'(1) << 1) | (32'(1) << 5); #1;
      chk(best_vld_o[0] && best_id_o[5:0] == 6'd33, "R10 tie lower id",
          64'(best_id_o[5:0]), 33);
      chk_shared("R10 tie pattern");

      // R7 input low drops
      @(negedge clk); spi_in = 32'(1) << 1; #1;
      chk(fw(0)[33] == 1'b1, "R7 line high", 64'(fw(0)[33]), 1);
      @(negedge clk); spi_in = '0; #1;
      chk(fw(0)[33] == 1'b0, "R7 line low", 64'(fw(0)[33]), 0);

      // R4 banking of private enables
      wr(12'h100, 32'hffff_0020, 1'b1);
      @(negedge clk); ppi_in = '1; #1;
      chk(fw(1) == 64'hffff_0000, "R4 core1 ppi", fw(1), 64'hffff_0000);
      chk(fw(0) == 64'h0, "R4 core0 untouched", fw(0), 0);
      rd(12'h100, 1'b0, d); chk(d == 0, "R11 bank0 read", 64'(d), 0);
      rd(12'h100, 1'b1, d); chk(d == 32'hffff_0020, "R11 bank1 read", 64'(d), 64'hffff_0020);

      // R8 ack of non-forwarded id is ignored
      ack(0, 20);
      wr(12'h100, 32'h0010_0020, 1'b0);
      chk(fw(0) == 64'h0010_0000, "R8 ignored ack", fw(0), 64'h0010_0000);

      // R8 private ack/eoi
      ack(1, 20);
      chk(fw(1)[20] == 1'b0, "R8 core1 active", 64'(fw(1)[20]), 0);
      chk(fw(0)[20] == 1'b1, "R4 core0 copy kept", 64'(fw(0)[20]), 1);
      eoi(1, 20);
      chk(fw(1)[20] == 1'b1, "R8 eoi restores", 64'(fw(1)[20]), 1);

      // R6 software interrupts
      wr(12'h004, (32'(1) << 16) | 32'd5, 1'b1);
      chk(fw(0)[5] == 1'b1, "R6 sgi pending core0", 64'(fw(0)[5]), 1);
      chk(sgi_src_o[5] == 1'b1, "R6 source core0", 64'(sgi_src_o[5]), 1);
      chk(fw(1)[5] == 1'b0, "R6 untargeted core1", 64'(fw(1)[5]), 0);
      repeat (5) @(negedge clk);
      #1;
      chk(fw(0)[5] == 1'b1, "R6 sgi held", 64'(fw(0)[5]), 1);
      wr(12'h004, (32'(3) << 16) | 32'd5, 1'b0);
      chk(sgi_src_o[5] == 1'b0, "R6 source updated core0", 64'(sgi_src_o[5]), 0);
      chk(fw(1)[5] == 1'b1, "R6 sgi pending core1", 64'(fw(1)[5]), 1);
      chk(sgi_src_o[21] == 1'b0, "R6 source core1", 64'(sgi_src_o[21]), 0);
      ack(0, 5);
      chk(fw(0)[5] == 1'b0, "R8 sgi ack clears", 64'(fw(0)[5]), 0);
      chk(fw(1)[5] == 1'b1, "R8 other core sgi kept", 64'(fw(1)[5]), 1);

      // R2 disable then re-enable keeps pending sgi
      wr(12'h000, 32'h0, 1'b0);
      chk(fwd_o == '0, "R2 disabled again", 64'(fwd_o[63:0] | fwd_o[127:64]), 0);
      chk(best_vld_o == '0, "R2 no best", 64'(best_vld_o), 0);
      wr(12'h000, 32'h1, 1'b0);
      chk(fw(1)[5] == 1'b1, "R2 sgi retained", 64'(fw(1)[5]), 1);

      // R9 shared active across cores
      @(negedge clk); ppi_in = '0; spi_in = 32'(1) << 3; #1;
      chk(fw(0)[35] && fw(1)[35], "R9 both see id35", 64'({fw(0)[35], fw(1)[35]}), 3);
      ack(0, 35);
      chk(!fw(0)[35] && !fw(1)[35], "R9 active hides both", 64'({fw(0)[35], fw(1)[35]}), 0);
      eoi(1, 35);
      chk(fw(0)[35] && fw(1)[35], "R9 eoi releases", 64'({fw(0)[35], fw(1)[35]}), 3);

      // R11 readback and R5 ignored private target
      rd(12'h494, 1'b0, d); chk(d == 5, "R11 prio read", 64'(d), 5);
      rd(12'h88C, 1'b0, d); chk(d == 3, "R11 target read", 64'(d), 3);
      rd(12'h000, 1'b0, d); chk(d == 1, "R11 ctrl read", 64'(d), 1);
      rd(12'h104, 1'b0, d); chk(d == 32'hffff_ffff, "R11 enable read", 64'(d), 64'hffff_ffff);
      wr(12'h828, 32'h3, 1'b0);
      rd(12'h828, 1'b0, d); chk(d == 0, "R5 private target ignored", 64'(d), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule